// File: doc/BRIEF.md
# UART In-Band Software Flow Controller

This block adds XON/XOFF pacing to a single UART channel, working in both directions. Toward the far end, it watches the fill level of the local receive FIFO. When the level climbs to a programmed stop point, it asks the transmitter to send a stop token. Once the level has fallen back to a programmed resume point, it asks for a resume token. Tokens travel through the normal transmit path and are cut to the active word length.

Toward the local side, it examines every received character. A stop token drops the transmit-enable output and a resume token raises it again. Matched token characters are removed from the stream before it reaches the receive FIFO. A level-based receive interrupt is raised while the FIFO holds at least a programmed number of characters.

Each of the three thresholds is a 4-bit nibble multiplied by four, so `0xF` means 60 characters. Tokens are either one or two characters long. The block assumes hardware RTS/CTS pacing is switched off. Received characters arrive at least two clock cycles apart, as any serial receiver delivers them.

Top module: `sfc_top`

## Requirements
- R1: After reset, `tx_enable` is 1 and `tok_req`, `rx_irq` and `rx_wr_en` are 0.
- R2: With `cfg_stop_nib` nonzero, no stop outstanding and `rx_level >= 4*cfg_stop_nib`, one stop-token sequence is requested (`tok_req` rises one cycle later). While the stop stays outstanding, no further stop is requested, however long the level stays high.
- R3: A resume-token sequence is requested only while a stop is outstanding and `rx_level <= 4*cfg_resume_nib`. No resume is ever requested without an outstanding stop.
- R4: `tok_req` and `tok_data` hold until the cycle in which `tok_ack` is sampled high. In two-character mode (`cfg_two_char`=1), the first token character is sent, then the second. `tok_req` falls one cycle after the last acknowledge.
- R5: The word length is encoded in `cfg_word_len` as 0=5, 1=6, 2=7 and 3=8 bits. `tok_data` carries only the low word-length bits of the token, and all bits above are 0.
- R6: `rx_irq` equals, one cycle later, (`cfg_irq_nib` != 0 and `rx_level >= 4*cfg_irq_nib`). It clears when the level drops below the threshold.
- R7: In one-character mode, a received character whose low word-length bits equal those of `cfg_xoff1` clears `tx_enable` one cycle later and is not written to the FIFO. A match with `cfg_xon1` sets `tx_enable` in the same way. The stop match wins when both tokens match.
- R8: A received character that is not a token is presented on `rx_wr_data` with `rx_wr_en` for one cycle, one cycle after its strobe, unchanged.
- R9: In two-character mode, the first and second characters of a token received in sequence apply that token, and neither character is written.
- R10: In two-character mode, a held first token character followed by a non-matching character is written as data one cycle after the second strobe. If that second character does not itself start a token, it is written one cycle later. If it does start a token, it becomes the new held character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word_len | input | 2 | Word length code (0..3 = 5..8 bits) |
| cfg_two_char | input | 1 | 1 selects two-character tokens |
| cfg_xon1 | input | 8 | Resume token, first character |
| cfg_xon2 | input | 8 | Resume token, second character |
| cfg_xoff1 | input | 8 | Stop token, first character |
| cfg_xoff2 | input | 8 | Stop token, second character |
| cfg_stop_nib | input | 4 | Stop threshold nibble (level = 4x, 0 disables) |
| cfg_resume_nib | input | 4 | Resume threshold nibble (level = 4x) |
| cfg_irq_nib | input | 4 | Receive interrupt nibble (level = 4x, 0 disables) |
| rx_level | input | 7 | Current receive FIFO fill level |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| rx_wr_en | output | 1 | Write strobe toward the receive FIFO |
| rx_wr_data | output | 8 | Data toward the receive FIFO |
| tok_req | output | 1 | Token send request to the transmitter |
| tok_data | output | 8 | Token character, truncated to word length |
| tok_ack | input | 1 | Transmitter has taken the token character |
| tx_enable | output | 1 | Local transmitter may send data |
| rx_irq | output | 1 | Receive-threshold interrupt (level) |

## Verification
Each result becomes due after a fixed delay:
- `rx_irq` and the `tx_enable` change follow their cause by one register. The bench drives at a falling edge and samples at the falling edge after the next rising edge.
- A FIFO write shows one cycle after its strobe. The replayed second character of a broken two-character pair shows one cycle after that.
- `tok_req` rises one cycle after the level crosses a threshold.

The monitor scores token characters at the falling edge on which it raises `tok_ack`, while `tok_data` is still stable. FIFO writes are scored at each falling edge on which `rx_wr_en` is high. Any write or token that arrives with nothing expected counts as a failure, which catches both repeated stops and unsolicited resumes.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   localparam int unsigned CHAR_W = 8;

   typedef enum logic [1:0] {
      TG_IDLE   = 2'd0,
      TG_FIRST  = 2'd1,
      TG_SECOND = 2'd2
   } tg_state_t;

   typedef enum logic [1:0] {
      PEND_NONE = 2'd0,
      PEND_XON  = 2'd1,
      PEND_XOFF = 2'd2
   } pend_t;

   // Low bits kept for a word length code (0..3 -> 5..8 bits)
   function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] wl);
      return {CHAR_W{1'b1}} >> (2'd3 - wl);
   endfunction
endpackage

// File: rtl/sfc_level_cmp.sv
module sfc_level_cmp #(
   parameter int unsigned LEVEL_W  = 7,
   parameter int unsigned NIB_W    = 4,
   parameter int unsigned SCALE_SH = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] level,
   input  logic [NIB_W-1:0]   stop_nib,
   input  logic [NIB_W-1:0]   resume_nib,
   input  logic [NIB_W-1:0]   irq_nib,
   output logic               stop_en,
   output logic               at_stop,
   output logic               at_resume,
   output logic               irq
);
   localparam int unsigned THR_W = NIB_W + SCALE_SH;

   if (LEVEL_W < THR_W) begin : g_bad_width
      $error("sfc_level_cmp: LEVEL_W too small for scaled thresholds");
   end

   logic [LEVEL_W-1:0] stop_thr, resume_thr, irq_thr;

   assign stop_thr   = LEVEL_W'({stop_nib,   {SCALE_SH{1'b0}}});
   assign resume_thr = LEVEL_W'({resume_nib, {SCALE_SH{1'b0}}});
   assign irq_thr    = LEVEL_W'({irq_nib,    {SCALE_SH{1'b0}}});

   assign stop_en   = (stop_nib != '0);
   assign at_stop   = (level >= stop_thr);
   assign at_resume = (level <= resume_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (irq_nib != '0) && (level >= irq_thr);
   end
endmodule

// File: rtl/sfc_tok_gen.sv
module sfc_tok_gen
   import sfc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_en,
   input  logic              at_stop,
   input  logic              at_resume,
   input  logic              two_char,
   input  logic [CHAR_W-1:0] mask,
   input  logic [CHAR_W-1:0] xon1,
   input  logic [CHAR_W-1:0] xon2,
   input  logic [CHAR_W-1:0] xoff1,
   input  logic [CHAR_W-1:0] xoff2,
   input  logic              tok_ack,
   output logic              tok_req,
   output logic [CHAR_W-1:0] tok_data
);
   tg_state_t state;
   logic      seq_is_stop;
   logic      stop_out;
   logic [CHAR_W-1:0] raw_char;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= TG_IDLE;
         seq_is_stop <= 1'b0;
         stop_out    <= 1'b0;
      end else begin
         unique case (state)
            TG_IDLE: begin
               if (stop_en && at_stop && !stop_out) begin
                  state       <= TG_FIRST;
                  seq_is_stop <= 1'b1;
                  stop_out    <= 1'b1;
               end else if (stop_out && at_resume) begin
                  state       <= TG_FIRST;
                  seq_is_stop <= 1'b0;
                  stop_out    <= 1'b0;
               end
            end
            TG_FIRST: begin
               if (tok_ack) state <= two_char ? TG_SECOND : TG_IDLE;
            end
            TG_SECOND: begin
               if (tok_ack) state <= TG_IDLE;
            end
            default: state <= TG_IDLE;
         endcase
      end
   end

   always_comb begin
      if (state == TG_SECOND) raw_char = seq_is_stop ? xoff2 : xon2;
      else                    raw_char = seq_is_stop ? xoff1 : xon1;
   end

   assign tok_req  = (state != TG_IDLE);
   assign tok_data = raw_char & mask;
endmodule

// File: rtl/sfc_rx_match.sv
module sfc_rx_match
   import sfc_pkg::*;
#(
   parameter bit TWO_CHAR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              two_char,
   input  logic [CHAR_W-1:0] mask,
   input  logic [CHAR_W-1:0] xon1,
   input  logic [CHAR_W-1:0] xon2,
   input  logic [CHAR_W-1:0] xoff1,
   input  logic [CHAR_W-1:0] xoff2,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   output logic              wr_en,
   output logic [CHAR_W-1:0] wr_data,
   output logic              tx_en
);
   localparam int unsigned N_TOK = 4;

   logic [CHAR_W-1:0] tok_tab [N_TOK];
   logic [N_TOK-1:0]  hit;
   logic              two_eff;

   assign tok_tab[0] = xoff1;
   assign tok_tab[1] = xon1;
   assign tok_tab[2] = xoff2;
   assign tok_tab[3] = xon2;

   for (genvar i = 0; i < N_TOK; i++) begin : g_cmp
      assign hit[i] = ((rx_data & mask) == (tok_tab[i] & mask));
   end

   if (TWO_CHAR_EN) begin : g_two
      assign two_eff = two_char;
   end else begin : g_one
      assign two_eff = 1'b0;
   end

   pend_t             pend;
   logic [CHAR_W-1:0] held;
   logic              replay_vld;
   logic [CHAR_W-1:0] replay;
   logic              second_hit;

   assign second_hit = (pend == PEND_XOFF) ? hit[2] : hit[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en      <= 1'b0;
         wr_data    <= '0;
         tx_en      <= 1'b1;
         pend       <= PEND_NONE;
         held       <= '0;
         replay_vld <= 1'b0;
         replay     <= '0;
      end else begin
         wr_en <= 1'b0;
         if (replay_vld) begin
            wr_en      <= 1'b1;
            wr_data    <= replay;
            replay_vld <= 1'b0;
         end
         if (rx_valid) begin
            if (pend == PEND_NONE || !two_eff) begin
               if (hit[0]) begin
                  if (two_eff) begin
                     pend <= PEND_XOFF;
                     held <= rx_data;
                  end else begin
                     tx_en <= 1'b0;
                  end
               end else if (hit[1]) begin
                  if (two_eff) begin
                     pend <= PEND_XON;
                     held <= rx_data;
                  end else begin
                     tx_en <= 1'b1;
                  end
               end else begin
                  wr_en   <= 1'b1;
                  wr_data <= rx_data;
               end
            end else if (second_hit) begin
               tx_en <= (pend == PEND_XON);
               pend  <= PEND_NONE;
            end else begin
               wr_en   <= 1'b1;
               wr_data <= held;
               if (hit[0]) begin
                  pend <= PEND_XOFF;
                  held <= rx_data;
               end else if (hit[1]) begin
                  pend <= PEND_XON;
                  held <= rx_data;
               end else begin
                  pend       <= PEND_NONE;
                  replay_vld <= 1'b1;
                  replay     <= rx_data;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sfc_top.sv
module sfc_top
   import sfc_pkg::*;
#(
   parameter int unsigned LEVEL_W     = 7,
   parameter int unsigned NIB_W       = 4,
   parameter int unsigned SCALE_SH    = 2,
   parameter bit          TWO_CHAR_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         cfg_word_len,
   input  logic               cfg_two_char,
   input  logic [7:0]         cfg_xon1,
   input  logic [7:0]         cfg_xon2,
   input  logic [7:0]         cfg_xoff1,
   input  logic [7:0]         cfg_xoff2,
   input  logic [NIB_W-1:0]   cfg_stop_nib,
   input  logic [NIB_W-1:0]   cfg_resume_nib,
   input  logic [NIB_W-1:0]   cfg_irq_nib,
   input  logic [LEVEL_W-1:0] rx_level,
   input  logic               rx_valid,
   input  logic [7:0]         rx_data,
   output logic               rx_wr_en,
   output logic [7:0]         rx_wr_data,
   output logic               tok_req,
   output logic [7:0]         tok_data,
   input  logic               tok_ack,
   output logic               tx_enable,
   output logic               rx_irq
);
   if (CHAR_W != 8) begin : g_bad_char
      $error("sfc_top: character width must be 8");
   end

   logic [CHAR_W-1:0] mask;
   logic stop_en, at_stop, at_resume;

   assign mask = char_mask(cfg_word_len);

   sfc_level_cmp #(
      .LEVEL_W(LEVEL_W), .NIB_W(NIB_W), .SCALE_SH(SCALE_SH)
   ) u_lvl (
      .clk(clk), .rst_n(rst_n), .level(rx_level),
      .stop_nib(cfg_stop_nib), .resume_nib(cfg_resume_nib), .irq_nib(cfg_irq_nib),
      .stop_en(stop_en), .at_stop(at_stop), .at_resume(at_resume), .irq(rx_irq)
   );

   sfc_tok_gen u_tok (
      .clk(clk), .rst_n(rst_n), .stop_en(stop_en), .at_stop(at_stop),
      .at_resume(at_resume), .two_char(cfg_two_char && TWO_CHAR_EN), .mask(mask),
      .xon1(cfg_xon1), .xon2(cfg_xon2), .xoff1(cfg_xoff1), .xoff2(cfg_xoff2),
      .tok_ack(tok_ack), .tok_req(tok_req), .tok_data(tok_data)
   );

   sfc_rx_match #(.TWO_CHAR_EN(TWO_CHAR_EN)) u_rx (
      .clk(clk), .rst_n(rst_n), .two_char(cfg_two_char), .mask(mask),
      .xon1(cfg_xon1), .xon2(cfg_xon2), .xoff1(cfg_xoff1), .xoff2(cfg_xoff2),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .wr_en(rx_wr_en), .wr_data(rx_wr_data), .tx_en(tx_enable)
   );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker
   import sfc_pkg::*;
#(
   parameter int unsigned LEVEL_W  = 7,
   parameter int unsigned NIB_W    = 4,
   parameter int unsigned SCALE_SH = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         cfg_word_len,
   input logic               cfg_two_char,
   input logic [7:0]         cfg_xon1,
   input logic [7:0]         cfg_xoff1,
   input logic [NIB_W-1:0]   cfg_stop_nib,
   input logic [NIB_W-1:0]   cfg_resume_nib,
   input logic [NIB_W-1:0]   cfg_irq_nib,
   input logic [LEVEL_W-1:0] rx_level,
   input logic               rx_valid,
   input logic [7:0]         rx_data,
   input logic               rx_wr_en,
   input logic               tok_req,
   input logic [7:0]         tok_data,
   input logic               tok_ack,
   input logic               tx_enable,
   input logic               rx_irq
);
   logic [7:0]         m;
   logic [LEVEL_W-1:0] irq_lvl, stop_lvl, res_lvl;
   logic               off_hit, on_hit, crossing;

   assign m        = char_mask(cfg_word_len);
   assign irq_lvl  = LEVEL_W'(cfg_irq_nib) << SCALE_SH;
   assign stop_lvl = LEVEL_W'(cfg_stop_nib) << SCALE_SH;
   assign res_lvl  = LEVEL_W'(cfg_resume_nib) << SCALE_SH;
   assign off_hit  = rx_valid && !cfg_two_char && ((rx_data & m) == (cfg_xoff1 & m));
   assign on_hit   = rx_valid && !cfg_two_char && ((rx_data & m) == (cfg_xon1 & m));
   assign crossing = (rx_level >= stop_lvl) || (rx_level <= res_lvl);

   AST_TOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tok_req && !tok_ack |=> tok_req && $stable(tok_data)); // R4
   AST_TOK_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
      tok_req |-> ((tok_data & ~m) == 8'h00)); // R5
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_irq_nib != '0) && (rx_level >= irq_lvl) |=> rx_irq); // R6
   AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level < irq_lvl) |=> !rx_irq); // R6
   AST_STOP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      off_hit |=> !tx_enable && !rx_wr_en); // R7
   AST_RESUME_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      on_hit && !off_hit |=> tx_enable && !rx_wr_en); // R7
   AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tok_req) |-> $past(crossing)); // R2
endmodule

bind sfc_top sfc_checker #(.LEVEL_W(LEVEL_W), .NIB_W(NIB_W), .SCALE_SH(SCALE_SH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_word_len(cfg_word_len), .cfg_two_char(cfg_two_char),
   .cfg_xon1(cfg_xon1), .cfg_xoff1(cfg_xoff1), .cfg_stop_nib(cfg_stop_nib),
   .cfg_resume_nib(cfg_resume_nib), .cfg_irq_nib(cfg_irq_nib), .rx_level(rx_level),
   .rx_valid(rx_valid), .rx_data(rx_data), .rx_wr_en(rx_wr_en), .tok_req(tok_req),
   .tok_data(tok_data), .tok_ack(tok_ack), .tx_enable(tx_enable), .rx_irq(rx_irq)
);

// File: tb/tb_sfc_top.sv
module tb_sfc_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_word_len = 2'd3;
   logic       cfg_two_char = 1'b0;
   logic [7:0] cfg_xon1 = 8'h0D, cfg_xon2 = 8'h11, cfg_xoff1 = 8'h0F, cfg_xoff2 = 8'h13;
   logic [3:0] cfg_stop_nib = 4'hF, cfg_resume_nib = 4'h8, cfg_irq_nib = 4'hD;
   logic [6:0] rx_level = '0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_wr_en, tok_req, tx_enable, rx_irq;
   logic [7:0] rx_wr_data, tok_data;
   logic       tok_ack = 1'b0;

   int checks = 0, fails = 0, req_cnt = 0, tok_seen = 0;
   bit done = 1'b0;
   logic [7:0] exp_wr[$];
   logic [7:0] exp_tok[$];
   string      wr_tag = "R8", tok_tag = "R2";

   always #4 clk = ~clk;

   sfc_top dut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_wr_en) begin
            if (exp_wr.size() == 0) chk(1'b0, wr_tag, rx_wr_data, 'hFFF);
            else begin
               automatic logic [7:0] e = exp_wr.pop_front();
               chk(rx_wr_data == e, wr_tag, rx_wr_data, e);
            end
         end
         if (tok_ack) begin
            tok_ack = 1'b0;
            req_cnt = 0;
         end else if (tok_req) begin
            req_cnt++;
            if (req_cnt >= 2) begin
               tok_seen++;
               if (exp_tok.size() == 0) chk(1'b0, tok_tag, tok_data, 'hFFF);
               else begin
                  automatic logic [7:0] e = exp_tok.pop_front();
                  chk(tok_data == e, tok_tag, tok_data, e);
               end
               tok_ack = 1'b1;
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_rx(input logic [7:0] d);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = d;
      @(negedge clk);
      rx_valid = 1'b0;
      idle(3);
   endtask

   task automatic set_level(input int lv, input int wait_n);
      @(negedge clk);
      rx_level = 7'(lv);
      idle(wait_n);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      idle(3);
      // R1 reset state
      chk(tx_enable == 1'b1, "R1", tx_enable, 1);
      chk(tok_req == 1'b0, "R1", tok_req, 0);
      chk(rx_irq == 1'b0 && rx_wr_en == 1'b0, "R1", {rx_irq, rx_wr_en}, 0);
      rst_n = 1'b1;
      idle(3);
      // R3: low level with no stop outstanding gives no token
      chk(tok_req == 1'b0, "R3", tok_req, 0);

      // R6 interrupt threshold 52
      set_level(52, 2);
      chk(rx_irq == 1'b1, "R6", rx_irq, 1);
      set_level(51, 2);
      chk(rx_irq == 1'b0, "R6", rx_irq, 0);

      // R2 stop token once per crossing
      tok_tag = "R2";
      exp_tok.push_back(8'h0F);
      set_level(60, 8);
      set_level(63, 30);
      chk(tok_seen == 1 && exp_tok.size() == 0, "R2", tok_seen, 1);
      // R3 resume at level 32
      tok_tag = "R3";
      set_level(33, 10);
      chk(tok_seen == 1, "R3", tok_seen, 1);
      exp_tok.push_back(8'h0D);
      set_level(32, 8);
      set_level(10, 20);
      chk(tok_seen == 2 && exp_tok.size() == 0, "R3", tok_seen, 2);

      // R5 truncation to 6 bits
      tok_tag = "R5";
      cfg_word_len = 2'd1;
      cfg_xoff1 = 8'hFF;
      cfg_xon1  = 8'hCD;
      exp_tok.push_back(8'h3F);
      set_level(60, 10);
      exp_tok.push_back(8'h0D);
      set_level(0, 10);
      chk(tok_seen == 4 && exp_tok.size() == 0, "R5", tok_seen, 4);
      cfg_word_len = 2'd3;
      cfg_xoff1 = 8'h0F;
      cfg_xon1  = 8'h0D;

      // R4 two-character token sequences
      tok_tag = "R4";
      cfg_two_char = 1'b1;
      exp_tok.push_back(8'h0F);
      exp_tok.push_back(8'h13);
      set_level(60, 14);
      exp_tok.push_back(8'h0D);
      exp_tok.push_back(8'h11);
      set_level(0, 14);
      chk(tok_seen == 8 && exp_tok.size() == 0, "R4", tok_seen, 8);
      chk(tok_req == 1'b0, "R4", tok_req, 0);
      cfg_two_char = 1'b0;
      idle(2);

      // R7 / R8 one-character matching
      wr_tag = "R8";
      exp_wr.push_back(8'h41);
      send_rx(8'h41);
      send_rx(8'h0F);
      chk(tx_enable == 1'b0, "R7", tx_enable, 0);
      exp_wr.push_back(8'h8D);
      send_rx(8'h8D);
      chk(tx_enable == 1'b0, "R8", tx_enable, 0);
      send_rx(8'h0D);
      chk(tx_enable == 1'b1, "R7", tx_enable, 1);
      cfg_word_len = 2'd2;
      send_rx(8'h8F);
      chk(tx_enable == 1'b0, "R7", tx_enable, 0);
      send_rx(8'h0D);
      cfg_word_len = 2'd3;
      chk(exp_wr.size() == 0, "R7", exp_wr.size(), 0);

      // R9 two-character matching
      cfg_two_char = 1'b1;
      idle(2);
      send_rx(8'h0F);
      send_rx(8'h13);
      chk(tx_enable == 1'b0, "R9", tx_enable, 0);
      send_rx(8'h0D);
      send_rx(8'h11);
      chk(tx_enable == 1'b1, "R9", tx_enable, 1);

      // R10 broken pairs
      wr_tag = "R10";
      exp_wr.push_back(8'h0F);
      exp_wr.push_back(8'h42);
      send_rx(8'h0F);
      send_rx(8'h42);
      chk(tx_enable == 1'b1, "R10", tx_enable, 1);
      exp_wr.push_back(8'h0D);
      send_rx(8'h0D);
      send_rx(8'h0F);
      send_rx(8'h13);
      chk(tx_enable == 1'b0, "R10", tx_enable, 0);
      idle(4);
      chk(exp_wr.size() == 0, "R10", exp_wr.size(), 0);
      chk(exp_tok.size() == 0, "R2", exp_tok.size(), 0);
      finish_run();
   end
endmodule